// File: doc/BRIEF.md
# Synchronous Sleep Mode Sequencer

This block steers a memory macro into and out of a low-power retention state. A sleep request arrives from outside the clock domain. It passes through a synchronizer and then drives a small state machine. The machine steps through a fixed entry phase, the sleep state, a fixed exit phase and a recovery window, and then returns to normal operation.

From the start of entry until the end of recovery, the block raises an inhibit output. The surrounding logic uses it to gate array enables and output drivers. Any access that was in flight when entry began is therefore dropped, and nothing can disturb the stored contents while the array sleeps.

The block also watches the chip-select and address-strobe lines of the memory. The protocol requires them to be idle at entry and during the recovery window. A select seen in either phase sets a sticky error flag, which only reset clears. Power switching itself is left to other logic.

Top module: `sleep_seq`

## Requirements
- R1: After reset, `sleep_active`, `access_inhibit` and `err_flag` are all 0. While `sleep_req` stays low (the level a pulled-down, unconnected input would give), the block stays awake.
- R2: `sleep_req` is sampled through a two-flop synchronizer. A level applied before rising edge k first affects the state machine at edge k+2.
- R3: Entry lasts two cycles. With `sleep_req` set high before edge k, `access_inhibit` rises at edge k+2 and `sleep_active` rises at edge k+3.
- R4: Exit lasts two cycles. With `sleep_req` set low before edge k while asleep, `sleep_active` stays high through edge k+2 and falls at edge k+3.
- R5: `access_inhibit` is 1 whenever `sleep_active` is 1. It is also 1 in the entry cycle and throughout the recovery window.
- R6: The recovery window lasts exactly `REC_CYC` cycles after `sleep_active` falls. `access_inhibit` falls at the end of that window.
- R7: `err_flag` is set in the cycle after any bit of `sel_i` is 1 during the entry cycle or a recovery cycle. That is, any cycle with `access_inhibit`=1 and `sleep_active`=0. Once set, it stays 1 until reset.
- R8: `sel_i` activity while fully awake, while asleep or during the exit phase has no effect on `err_flag`.
- R9: Entry, once started, always completes. If `sleep_req` is withdrawn during entry, the block still reaches sleep and then goes through a full exit and recovery.
- R10: A new entry starts only from the awake state. A request asserted during exit or recovery takes effect only after the recovery window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, high = sleep |
| sel_i | input | NUM_SEL | Active-high chip-select and strobe lines of the memory |
| sleep_active | output | 1 | Memory is in (or leaving) the sleep state |
| access_inhibit | output | 1 | Gate array access and output drive |
| err_flag | output | 1 | Sticky protocol violation flag |

## Verification
A wrong state shows at the ports within one or two cycles.

- A corrupted phase appears as `sleep_active` and `access_inhibit` disagreeing with the expected step sequence at the next edge.
- A recovery count that is off by one moves the falling edge of `access_inhibit` by a cycle.
- A wrong violation window shows up as `err_flag` rising in the cycle after a select it should have ignored, or staying low after one it should have flagged.

The reference model in the bench tracks all three outputs on every clock, so any of these faults is reported in the cycle where it first appears.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        PH_AWAKE   = 3'd0,
        PH_ENTER   = 3'd1,
        PH_ASLEEP  = 3'd2,
        PH_EXIT    = 3'd3,
        PH_RECOVER = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   err;
    } ctl_t;

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_rec_timer.sv
module sleep_rec_timer #(
    parameter int REC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic zero
);
    localparam int CW = (REC_CYC < 2) ? 1 : $clog2(REC_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(REC_CYC - 1);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleep_seq_pkg::*;
#(
    parameter int NUM_SEL     = 5,
    parameter int REC_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic [NUM_SEL-1:0] sel_i,
    output logic               sleep_active,
    output logic               access_inhibit,
    output logic               err_flag
);
    ctl_t ctl_d, ctl_q;
    logic req_s;
    logic tmr_start;
    logic tmr_zero;
    logic any_sel;
    logic viol;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(sleep_req),
        .sync_o (req_s)
    );

    sleep_rec_timer #(.REC_CYC(REC_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tmr_start),
        .zero (tmr_zero)
    );

    assign any_sel = |sel_i;

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        viol      = 1'b0;
        unique case (ctl_q.phase)
            PH_AWAKE: begin
                if (req_s) ctl_d.phase = PH_ENTER;
            end
            PH_ENTER: begin
                viol        = any_sel;
                ctl_d.phase = PH_ASLEEP;
            end
            PH_ASLEEP: begin
                if (!req_s) ctl_d.phase = PH_EXIT;
            end
            PH_EXIT: begin
                tmr_start   = 1'b1;
                ctl_d.phase = PH_RECOVER;
            end
            PH_RECOVER: begin
                viol = any_sel;
                if (tmr_zero) ctl_d.phase = PH_AWAKE;
            end
            default: ctl_d.phase = PH_AWAKE;
        endcase
        ctl_d.err = ctl_q.err | viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{phase: PH_AWAKE, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign sleep_active   = (ctl_q.phase == PH_ASLEEP) || (ctl_q.phase == PH_EXIT);
    assign access_inhibit = (ctl_q.phase != PH_AWAKE);
    assign err_flag       = ctl_q.err;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
    parameter int NUM_SEL = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SEL-1:0] sel_i,
    input logic               sleep_active,
    input logic               access_inhibit,
    input logic               err_flag
);
    AST_SLEEP_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_active |-> access_inhibit); // R5

    AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> $past(access_inhibit)); // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R7

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(access_inhibit && !sleep_active && (|sel_i))); // R7

    AST_NO_ERR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !(access_inhibit && !sleep_active)) |=> !err_flag); // R8

    AST_RECOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(access_inhibit) |-> $past(!sleep_active)); // R6
endmodule

bind sleep_seq sleep_seq_chk #(.NUM_SEL(NUM_SEL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_i         (sel_i),
    .sleep_active  (sleep_active),
    .access_inhibit(access_inhibit),
    .err_flag      (err_flag)
);

// File: tb/sleep_seq_test.sv
`timescale 1ns/1ps
module sleep_seq_test;
    localparam int NS  = 5;
    localparam int REC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [NS-1:0] sel = '0;
    logic          sa, inh, err;

    int n_run  = 0;
    int n_fail = 0;

    sleep_seq #(.NUM_SEL(NS), .REC_CYC(REC)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(req), .sel_i(sel),
        .sleep_active(sa), .access_inhibit(inh), .err_flag(err)
    );

    always #5 clk = ~clk;

    // Behavioural reference: request delay line plus a phase number.
    // Phases: 0 awake, 1 entering, 2 asleep, 3 exiting, 4 recovering.
    logic q1 = 1'b0, q2 = 1'b0;
    int   m_ph = 0, m_cnt = 0;
    logic m_err = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q1 = 1'b0; q2 = 1'b0; m_ph = 0; m_cnt = 0; m_err = 1'b0;
        end else begin
            if ((m_ph == 1 || m_ph == 4) && sel != '0) m_err = 1'b1;
            case (m_ph)
                0: if (q2) m_ph = 1;
                1: m_ph = 2;
                2: if (!q2) m_ph = 3;
                3: begin m_ph = 4; m_cnt = REC; end
                default: begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt == 0) m_ph = 0;
                end
            endcase
            q2 = q1;
            q1 = req;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3/R4 sleep_active model", sa,  (m_ph == 2 || m_ph == 3));
            chk("R5/R6 access_inhibit model", inh, (m_ph != 0));
            chk("R7/R8 err_flag model", err, m_err);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 1'b0; sel = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 reset sleep_active", sa, 1'b0);
        chk("R1 reset inhibit", inh, 1'b0);
        chk("R1 reset err", err, 1'b0);

        // R8: selects while awake are harmless
        sel = 5'b10101; step(3); sel = '0;
        chk("R8 awake sel no err", err, 1'b0);
        chk("R1 stays awake with low request", inh, 1'b0);

        // R2/R3: entry timing
        req = 1'b1;
        step(2);
        chk("R2 synchronizer delay", inh, 1'b0);
        step(1);
        chk("R3 entry cycle inhibit", inh, 1'b1);
        chk("R3 entry cycle not yet asleep", sa, 1'b0);
        step(1);
        chk("R3 asleep after two cycles", sa, 1'b1);

        // R8: selects while asleep are ignored
        sel = 5'b00011; step(4); sel = '0;
        chk("R8 asleep sel no err", err, 1'b0);

        // R4/R6: exit timing and recovery length
        req = 1'b0;
        step(3);
        chk("R4 exit phase still asleep", sa, 1'b1);
        step(1);
        chk("R4 sleep_active falls", sa, 1'b0);
        chk("R6 recovery inhibit", inh, 1'b1);
        step(REC - 1);
        chk("R6 last recovery cycle", inh, 1'b1);
        step(1);
        chk("R6 recovery ends", inh, 1'b0);
        chk("R8 no err after clean cycle", err, 1'b0);

        // R7: select during recovery
        req = 1'b1; step(6); req = 1'b0;
        step(4);
        chk("R7 in recovery", inh & ~sa, 1'b1);
        sel = 5'b01000; step(1); sel = '0;
        chk("R7 err after recovery select", err, 1'b1);
        step(10);
        chk("R7 err sticky", err, 1'b1);

        // R7: select during entry
        do_reset();
        chk("R1 reset clears err", err, 1'b0);
        req = 1'b1; step(3);
        chk("R7 in entry cycle", inh & ~sa, 1'b1);
        sel = 5'b10000; step(1); sel = '0;
        chk("R7 err after entry select", err, 1'b1);

        // R9: request withdrawn during entry
        do_reset();
        req = 1'b1; step(3); req = 1'b0;
        step(1);
        chk("R9 entry completes", sa, 1'b1);
        step(4);
        chk("R9 exit then recovery", inh & ~sa, 1'b1);
        step(REC);
        chk("R9 back awake", inh, 1'b0);

        // R10: request reasserted during recovery waits for the window
        req = 1'b1; step(6); req = 1'b0; step(4);
        req = 1'b1;
        step(REC - 1);
        chk("R10 recovery not cut short", inh & ~sa, 1'b1);
        step(1);
        chk("R10 awake between windows", inh, 1'b0);
        step(1);
        chk("R10 new entry begins", inh, 1'b1);
        step(1);
        chk("R10 asleep again", sa, 1'b1);
        req = 1'b0; step(12);
        chk("R10 final awake", inh, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule